// File: doc/BRIEF.md
# Eight-pin GPIO port with bus register file

This block is an eight-pin general-purpose I/O port that sits behind a 32-bit APB slave interface. The port decodes a 4 KB window and takes word accesses only. It holds three kinds of state. A stored output value and a direction vector drive the pad output-enable and output-value lines. An alternate-function select vector is held for the pad multiplexer. A set of interrupt configuration vectors (sense, both-edge, event polarity and enable) is handed to a separate detection unit. In return, that unit supplies its raw pending vector, and the block sends it one-cycle clear pulses.

Pad inputs pass through a two-stage synchroniser. Both the register read path and the detection unit see the synchronised value. The data word is aliased 256 times in the low 1 KB. Address bits [9:2] act as a per-pin mask. A read returns only the selected pins. A write alters only the selected pins, so software can drive single pins without a read-modify-write sequence. Eight fixed identification bytes occupy the top of the window.

Top module: `gpio_apb_port`

## Requirements
- R1: After reset, the direction, stored output, alternate select and all four interrupt configuration vectors are zero. `pad_oe` and `pad_out` are then 0x00, and `irq_clear` is 0x00.
- R2: A read at any offset from 0x000 to 0x3FC returns, in `prdata[7:0]`, the pin view ANDed with mask `paddr[9:2]`. `prdata[31:8]` is zero.
- R3: A write at offset 0x000 to 0x3FC replaces the stored-output bits where `paddr[9:2]` is 1 with `pwdata`. Bits where the mask is 0 keep their value.
- R4: The direction vector at offset 0x400 is read/write. Bit value 1 makes that pin an output, and 0 makes it an input. `pad_oe` equals the direction vector, and `pad_out` equals the stored output value.
- R5: In the pin view, an output pin shows its stored output value. An input pin shows its pad level, delayed by the two synchroniser stages. A change on `pad_in` applied before a rising edge appears in a read after the second rising edge, and not after the first.
- R6: The interrupt sense (0x404), both-edge (0x408), event (0x40C) and enable (0x410) vectors are read/write in bits [7:0]. Each drives its own output.
- R7: Offset 0x414 returns `irq_raw`. Offset 0x418 returns `irq_raw` ANDed with the enable vector.
- R8: A write to 0x41C drives `pwdata[7:0]` on `irq_clear` for exactly the one cycle after the access. A read of 0x41C returns zero.
- R9: The alternate-function select vector at 0x420 is read/write and drives `alt_sel`.
- R10: Offsets 0xFE0, 0xFE4, 0xFE8, 0xFEC, 0xFF0, 0xFF4, 0xFF8 and 0xFFC read 0x61, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1 respectively.
- R11: Reads of any other offset return zero, and writes to them change no state. `pready` is always 1 and `pslverr` is always 0.
- R12: State changes only on a write access phase (`psel`, `penable` and `pwrite` all high). A setup-only write cycle changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address within window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Pad output enables |
| pad_out | output | 8 | Pad output values |
| alt_sel | output | 8 | Alternate-function select |
| pins_sync | output | 8 | Synchronised pad levels for the detection unit |
| irq_sense | output | 8 | Level (1) / edge (0) select |
| irq_both | output | 8 | Both-edge select |
| irq_event | output | 8 | Event polarity select |
| irq_en | output | 8 | Interrupt enable |
| irq_raw | input | 8 | Raw pending vector from detection unit |
| irq_clear | output | 8 | One-cycle clear pulse |

## Verification
Two functions can land in the same clock edge: a masked data write and a pad-level change on another pin. The pin view merges stored output bits with synchronised input bits, so a fault in either the mask path or the direction-select path could corrupt the other. The bench provokes this by changing `pad_in` in the same cycle as a masked write's access phase, on a port split half input, half output. It then judges the full-mask readback: the output nibble must reflect only the masked write, and the input nibble must show the new pad level.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PIN_W  = 8;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned WORD_W = ADDR_W - 2;

  // word indices (paddr[11:2])
  localparam logic [WORD_W-1:0] W_DIR    = 10'h100;
  localparam logic [WORD_W-1:0] W_SENSE  = 10'h101;
  localparam logic [WORD_W-1:0] W_BOTH   = 10'h102;
  localparam logic [WORD_W-1:0] W_EVENT  = 10'h103;
  localparam logic [WORD_W-1:0] W_ENABLE = 10'h104;
  localparam logic [WORD_W-1:0] W_RAW    = 10'h105;
  localparam logic [WORD_W-1:0] W_MASKED = 10'h106;
  localparam logic [WORD_W-1:0] W_CLEAR  = 10'h107;
  localparam logic [WORD_W-1:0] W_ALT    = 10'h108;
  localparam logic [WORD_W-4:0] W_ID_HI  = 7'h7F;

  function automatic logic [PIN_W-1:0] ident_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    ident_byte = 8'h61;
      3'd1:    ident_byte = 8'h10;
      3'd2:    ident_byte = 8'h04;
      3'd3:    ident_byte = 8'h00;
      3'd4:    ident_byte = 8'h0D;
      3'd5:    ident_byte = 8'hF0;
      3'd6:    ident_byte = 8'h05;
      default: ident_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] waddr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  data_q,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  sense_q,
  output logic [PIN_W-1:0]  both_q,
  output logic [PIN_W-1:0]  event_q,
  output logic [PIN_W-1:0]  enable_q,
  output logic [PIN_W-1:0]  alt_q,
  output logic [PIN_W-1:0]  clear_q
);
  localparam int unsigned MSB = WORD_W - 1;

  logic             in_data_win;
  logic [PIN_W-1:0] win_mask;
  logic [PIN_W-1:0] data_d, dir_d, sense_d, both_d, event_d, enable_d, alt_d, clear_d;

  assign in_data_win = (waddr[MSB:MSB-1] == 2'b00);
  assign win_mask    = waddr[PIN_W-1:0];

  always_comb begin
    data_d   = data_q;
    dir_d    = dir_q;
    sense_d  = sense_q;
    both_d   = both_q;
    event_d  = event_q;
    enable_d = enable_q;
    alt_d    = alt_q;
    clear_d  = '0;
    if (wr_en) begin
      if (in_data_win) begin
        data_d = (wdata & win_mask) | (data_q & ~win_mask);
      end else begin
        case (waddr)
          W_DIR:    dir_d    = wdata;
          W_SENSE:  sense_d  = wdata;
          W_BOTH:   both_d   = wdata;
          W_EVENT:  event_d  = wdata;
          W_ENABLE: enable_d = wdata;
          W_CLEAR:  clear_d  = wdata;
          W_ALT:    alt_d    = wdata;
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      sense_q  <= '0;
      both_q   <= '0;
      event_q  <= '0;
      enable_q <= '0;
      alt_q    <= '0;
      clear_q  <= '0;
    end else begin
      data_q   <= data_d;
      dir_q    <= dir_d;
      sense_q  <= sense_d;
      both_q   <= both_d;
      event_q  <= event_d;
      enable_q <= enable_d;
      alt_q    <= alt_d;
      clear_q  <= clear_d;
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
(
  input  logic              rd_en,
  input  logic [WORD_W-1:0] raddr,
  input  logic [PIN_W-1:0]  pin_view,
  input  logic [PIN_W-1:0]  dir_q,
  input  logic [PIN_W-1:0]  sense_q,
  input  logic [PIN_W-1:0]  both_q,
  input  logic [PIN_W-1:0]  event_q,
  input  logic [PIN_W-1:0]  enable_q,
  input  logic [PIN_W-1:0]  alt_q,
  input  logic [PIN_W-1:0]  raw_i,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned MSB = WORD_W - 1;

  logic [PIN_W-1:0] sel_byte;

  always_comb begin
    sel_byte = '0;
    if (raddr[MSB:MSB-1] == 2'b00) begin
      sel_byte = pin_view & raddr[PIN_W-1:0];
    end else if (raddr[MSB:3] == W_ID_HI) begin
      sel_byte = ident_byte(raddr[2:0]);
    end else begin
      case (raddr)
        W_DIR:    sel_byte = dir_q;
        W_SENSE:  sel_byte = sense_q;
        W_BOTH:   sel_byte = both_q;
        W_EVENT:  sel_byte = event_q;
        W_ENABLE: sel_byte = enable_q;
        W_RAW:    sel_byte = raw_i;
        W_MASKED: sel_byte = raw_i & enable_q;
        W_ALT:    sel_byte = alt_q;
        default:  sel_byte = '0;
      endcase
    end
    rdata = rd_en ? {{(DATA_W-PIN_W){1'b0}}, sel_byte} : '0;
  end
endmodule

// File: rtl/gpio_apb_port.sv
module gpio_apb_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [PIN_W-1:0]  pad_in,
  output logic [PIN_W-1:0]  pad_oe,
  output logic [PIN_W-1:0]  pad_out,
  output logic [PIN_W-1:0]  alt_sel,
  output logic [PIN_W-1:0]  pins_sync,
  output logic [PIN_W-1:0]  irq_sense,
  output logic [PIN_W-1:0]  irq_both,
  output logic [PIN_W-1:0]  irq_event,
  output logic [PIN_W-1:0]  irq_en,
  input  logic [PIN_W-1:0]  irq_raw,
  output logic [PIN_W-1:0]  irq_clear
);
  logic              wr_en, rd_en;
  logic [WORD_W-1:0] word_addr;
  logic [PIN_W-1:0]  data_q, dir_q, pin_view;

  assign word_addr = paddr[ADDR_W-1:2];
  assign wr_en     = psel && penable && pwrite;
  assign rd_en     = psel && !pwrite;
  assign pready    = 1'b1;
  assign pslverr   = 1'b0;

  gpio_pad_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_sync)
  );

  gpio_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(word_addr),
    .wdata(pwdata[PIN_W-1:0]),
    .data_q(data_q), .dir_q(dir_q), .sense_q(irq_sense), .both_q(irq_both),
    .event_q(irq_event), .enable_q(irq_en), .alt_q(alt_sel), .clear_q(irq_clear)
  );

  assign pin_view = (dir_q & data_q) | (~dir_q & pins_sync);
  assign pad_oe   = dir_q;
  assign pad_out  = data_q;

  gpio_read_mux u_rmux (
    .rd_en(rd_en), .raddr(word_addr), .pin_view(pin_view), .dir_q(dir_q),
    .sense_q(irq_sense), .both_q(irq_both), .event_q(irq_event),
    .enable_q(irq_en), .alt_q(alt_sel), .raw_i(irq_raw), .rdata(prdata)
  );
endmodule

// File: rtl/gpio_apb_port_chk.sv
module gpio_apb_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic [11:0] paddr,
  input logic [31:0] prdata,
  input logic        pready,
  input logic        pslverr,
  input logic [7:0]  pad_oe,
  input logic [7:0]  pad_out,
  input logic [7:0]  irq_raw,
  input logic [7:0]  irq_clear
);
  logic acc_wr;
  assign acc_wr = psel && penable && pwrite;

  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R11

  AST_READ_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr[11:10] == 2'b00) |-> ((prdata & ~{24'h0, paddr[9:2]}) == 32'h0)); // R2

  AST_UNMASKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && paddr[11:10] == 2'b00) |=> ((pad_out & ~$past(paddr[9:2])) == ($past(pad_out) & ~$past(paddr[9:2])))); // R3

  AST_IDLE_KEEPS_PADS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> ($stable(pad_oe) && $stable(pad_out))); // R12

  AST_CLEAR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear != 8'h00) |-> $past(acc_wr && paddr == 12'h41C)); // R8

  AST_MASKED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && paddr == 12'h418) |-> ((prdata[7:0] & ~irq_raw) == 8'h00)); // R7
endmodule

bind gpio_apb_port gpio_apb_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pready(pready), .pslverr(pslverr),
  .pad_oe(pad_oe), .pad_out(pad_out), .irq_raw(irq_raw), .irq_clear(irq_clear)
);

// File: tb/gpio_apb_port_tb_top.sv
`timescale 1ns/1ps
module gpio_apb_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out, alt_sel, pins_sync;
  logic [7:0]  irq_sense, irq_both, irq_event, irq_en, irq_clear;
  logic [7:0]  irq_raw = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_apb_port dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .alt_sel(alt_sel), .pins_sync(pins_sync), .irq_sense(irq_sense),
    .irq_both(irq_both), .irq_event(irq_event), .irq_en(irq_en),
    .irq_raw(irq_raw), .irq_clear(irq_clear)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #0.5 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {24'h0, pad_out}, 32'h0);
    check("R1 irq_clear", {24'h0, irq_clear}, 32'h0);
    bus_read(12'h400, v); check("R1 dir", v, 32'h0);
    bus_read(12'h410, v); check("R1 enable", v, 32'h0);
    bus_read(12'h420, v); check("R1 alt", v, 32'h0);
  endtask

  task automatic t_masked_data;
    logic [31:0] v;
    bus_write(12'h400, 32'hFF);
    check("R4 pad_oe all out", {24'h0, pad_oe}, 32'hFF);
    bus_write(12'h3FC, 32'hFFFF_FFFF);
    check("R3 full write", {24'h0, pad_out}, 32'hFF);
    bus_write(12'h03C, 32'h0);
    check("R3 low nibble only", {24'h0, pad_out}, 32'hF0);
    bus_read(12'h3FC, v); check("R2 full mask read", v, 32'hF0);
    bus_read(12'h0C0, v); check("R2 mask 0x30 read", v, 32'h30);
    bus_read(12'h000, v); check("R2 zero mask read", v, 32'h0);
  endtask

  task automatic t_input_sync;
    logic [31:0] v;
    bus_write(12'h400, 32'h0F);
    check("R4 pad_oe split", {24'h0, pad_oe}, 32'h0F);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = 12'h3FC;
    pad_in = 8'hA5;
    @(negedge clk); #0.5;
    check("R5 one edge old", prdata, 32'h00);
    @(negedge clk); #0.5;
    check("R5 two edges new", prdata, 32'hA0);
    psel = 1'b0;
    check("R5 sync output", {24'h0, pins_sync}, 32'hA5);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h00C; pwdata = 32'h03;
    @(negedge clk);
    penable = 1'b1; pad_in = 8'h5A;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(12'h3FC, v);
    check("R3 R5 write with pad change", v, 32'h53);
    check("R3 stored value", {24'h0, pad_out}, 32'hF3);
  endtask

  task automatic t_cfg_regs;
    logic [31:0] v;
    bus_write(12'h404, 32'h11); bus_write(12'h408, 32'h22);
    bus_write(12'h40C, 32'h44); bus_write(12'h410, 32'h0F);
    bus_write(12'h420, 32'h81);
    check("R6 sense out", {24'h0, irq_sense}, 32'h11);
    check("R6 both out", {24'h0, irq_both}, 32'h22);
    check("R6 event out", {24'h0, irq_event}, 32'h44);
    bus_read(12'h410, v); check("R6 enable read", v, 32'h0F);
    bus_read(12'h408, v); check("R6 both read", v, 32'h22);
    check("R9 alt out", {24'h0, alt_sel}, 32'h81);
    bus_read(12'h420, v); check("R9 alt read", v, 32'h81);
    irq_raw = 8'h3C;
    bus_read(12'h414, v); check("R7 raw", v, 32'h3C);
    bus_read(12'h418, v); check("R7 masked", v, 32'h0C);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h41C; pwdata = 32'h96;
    @(negedge clk);
    penable = 1'b1;
    #0.5 check("R8 no pulse before edge", {24'h0, irq_clear}, 32'h0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    check("R8 pulse value", {24'h0, irq_clear}, 32'h96);
    @(negedge clk);
    check("R8 pulse ends", {24'h0, irq_clear}, 32'h0);
    bus_read(12'h41C, v); check("R8 reads zero", v, 32'h0);
  endtask

  task automatic t_ident;
    logic [31:0] v;
    logic [7:0] exp_id [8] = '{8'h61, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      bus_read(12'hFE0 + 12'(i * 4), v);
      check("R10 ident", v, {24'h0, exp_id[i]});
    end
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    bus_write(12'h424, 32'hFF);
    bus_write(12'h800, 32'hFF);
    bus_read(12'h424, v); check("R11 unmapped read 0x424", v, 32'h0);
    bus_read(12'h800, v); check("R11 unmapped read 0x800", v, 32'h0);
    bus_read(12'h400, v); check("R11 dir untouched", v, 32'h0F);
    bus_read(12'h420, v); check("R11 alt untouched", v, 32'h81);
    check("R11 pready", {31'h0, pready}, 32'h1);
    check("R11 pslverr", {31'h0, pslverr}, 32'h0);
  endtask

  task automatic t_setup_only;
    logic [31:0] v;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h400; pwdata = 32'hAA;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    bus_read(12'h400, v); check("R12 setup-only ignored", v, 32'h0F);
    check("R12 pad_oe kept", {24'h0, pad_oe}, 32'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masked_data();
    t_input_sync();
    t_same_cycle();
    t_cfg_regs();
    t_clear();
    t_ident();
    t_unmapped();
    t_setup_only();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule